// File: doc/BRIEF.md
# Raster Display Address Generator

This block produces the display memory address for a raster screen laid out as 40 bytes per line, one address per pixel-group clock enable. A video timing source supplies horizontal and vertical blanking strobes, and the block returns the byte address that the fetch logic should read next. The address starts at zero in the upper-left corner and rises left to right, then down the screen.

Two modes are supported. In bitmap mode every raster has its own 40 addresses, and a 200-raster frame ends at address 7999. In character mode each byte address names one 8x8 character cell. The same 40 addresses are replayed for the 8 rasters of a character row, and a 3-bit raster-in-cell count tells the glyph logic which pixel row of the cell to draw. A frame of 25 character rows ends at address 999. Both modes rely on one mechanism. The counter freezes during horizontal blanking, a latch stores where the next line must begin, and the counter is reloaded from that latch when active video resumes.

Top module: `raster_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the design sets `disp_addr` to 0 and `cell_row` to 0. The latch is cleared and the blanking history is taken as "in horizontal blanking".
- R2: On each clock with `pix_en`=1 and `hblank`=0, where the previous enabled sample also had `hblank`=0, `disp_addr` advances by one. In bitmap mode (`char_mode`=0), 200 lines of 40 enabled active samples reach 7999 on the last byte.
- R3: On a clock with `pix_en`=1, `hblank`=1 and `vblank`=0, `disp_addr` keeps its value.
- R4: On the first enabled sample with `hblank`=0 after an enabled sample with `hblank`=1, `disp_addr` is loaded from the line-start latch. In bitmap mode, each transition into horizontal blanking captures the address that follows the current one.
- R5: During vertical blanking the counter keeps stepping on active samples. An enabled sample with both `vblank`=1 and `hblank`=1 clears `disp_addr`, the latch and `cell_row` to 0.
- R6: In character mode, each transition into horizontal blanking advances `cell_row`, and 7 wraps to 0. The latch captures the next row start only on that wrap, so the same 40 addresses repeat for 8 lines.
- R7: In character mode, a frame of 25 rows of 8 lines ends with address 999 on its last byte.
- R8: Wrap: when the current address is at or above the mode limit (7999 bitmap, 999 character), the next step or the captured line start is 0.
- R9: In bitmap mode `cell_row` is 0 after every enabled clock.
- R10: A clock with `pix_en`=0 leaves `disp_addr` and `cell_row` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-group clock enable, one per display byte |
| hblank | input | 1 | Horizontal blanking, high while blanked |
| vblank | input | 1 | Vertical blanking, high while blanked |
| char_mode | input | 1 | 1 selects character mode, 0 selects bitmap mode |
| disp_addr | output | 13 | Display memory byte address |
| cell_row | output | 3 | Raster index inside the character cell (character mode) |

## Verification
The properties assume that `hblank` and `vblank` are sampled only through `pix_en`. They also assume that `char_mode` changes only while the frame is in vertical blanking, so that the mode limit seen by one step matches the limit seen by the next. The bench drives mode changes solely inside vertical-blanking lines. Every line has at least one enabled blanking sample, so each vertical interval clears the counter before the next frame. Enable gaps of one idle clock are mixed into the character-mode frame to exercise the hold behaviour without breaking these assumptions.

// File: rtl/rag_pkg.sv
package rag_pkg;
  typedef enum logic {
    MODE_BITMAP = 1'b0,
    MODE_CHAR   = 1'b1
  } disp_mode_e;

  typedef struct packed {
    logic clear;   // vertical-blank line boundary
    logic enter;   // first blanked sample of a line
    logic preset;  // first active sample of a line
    logic step;    // continuing active sample
  } line_evt_t;
endpackage

// File: rtl/rag_edge.sv
module rag_edge
  import rag_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pix_en,
  input  logic      hblank,
  input  logic      vblank,
  output line_evt_t evt
);
  logic hb_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_prev <= 1'b1;
    end else if (pix_en) begin
      hb_prev <= hblank;
    end
  end

  always_comb begin
    evt.clear  = pix_en & vblank & hblank;
    evt.enter  = pix_en & hblank & ~hb_prev & ~vblank;
    evt.preset = pix_en & ~hblank & hb_prev;
    evt.step   = pix_en & ~hblank & ~hb_prev;
  end
endmodule

// File: rtl/rag_row_ctr.sv
module rag_row_ctr
  import rag_pkg::*;
#(
  parameter int CELL_H = 8,
  localparam int RW = (CELL_H > 1) ? $clog2(CELL_H) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  disp_mode_e    mode,
  input  line_evt_t     evt,
  output logic [RW-1:0] row,
  output logic          row_wrap
);
  localparam logic [RW-1:0] ROW_TOP = RW'(CELL_H - 1);

  assign row_wrap = (mode == MODE_CHAR) & evt.enter & (row == ROW_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0;
    end else if (pix_en) begin
      if (mode != MODE_CHAR || evt.clear) begin
        row <= '0;
      end else if (evt.enter) begin
        row <= row_wrap ? '0 : row + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rag_addr_ctr.sv
module rag_addr_ctr
  import rag_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  line_evt_t     evt,
  input  logic          capture,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] start_q;
  logic [AW-1:0] addr_nx;

  assign addr_nx = (addr >= limit) ? '0 : addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      start_q <= '0;
    end else if (pix_en) begin
      if (evt.clear) begin
        addr    <= '0;
        start_q <= '0;
      end else begin
        if (evt.enter && capture) start_q <= addr_nx;
        if (evt.preset)           addr    <= start_q;
        else if (evt.step)        addr    <= addr_nx;
      end
    end
  end
endmodule

// File: rtl/raster_addr_gen.sv
module raster_addr_gen
  import rag_pkg::*;
#(
  parameter int BYTES_PER_LINE = 40,
  parameter int BMP_RASTERS    = 200,
  parameter int CHR_ROWS       = 25,
  parameter int CELL_H         = 8,
  localparam int BMP_LAST = BYTES_PER_LINE * BMP_RASTERS - 1,
  localparam int CHR_LAST = BYTES_PER_LINE * CHR_ROWS - 1,
  localparam int AW = $clog2(BMP_LAST + 1),
  localparam int RW = (CELL_H > 1) ? $clog2(CELL_H) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic          hblank,
  input  logic          vblank,
  input  logic          char_mode,
  output logic [AW-1:0] disp_addr,
  output logic [RW-1:0] cell_row
);
  localparam logic [AW-1:0] LIM_BMP = AW'(BMP_LAST);
  localparam logic [AW-1:0] LIM_CHR = AW'(CHR_LAST);

  disp_mode_e    mode;
  line_evt_t     evt;
  logic          row_wrap;
  logic          capture;
  logic [AW-1:0] limit;

  assign mode    = disp_mode_e'(char_mode);
  assign limit   = (mode == MODE_CHAR) ? LIM_CHR : LIM_BMP;
  assign capture = (mode == MODE_BITMAP) | row_wrap;

  rag_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .pix_en (pix_en),
    .hblank (hblank),
    .vblank (vblank),
    .evt    (evt)
  );

  rag_row_ctr #(.CELL_H(CELL_H)) u_row (
    .clk      (clk),
    .rst      (rst),
    .pix_en   (pix_en),
    .mode     (mode),
    .evt      (evt),
    .row      (cell_row),
    .row_wrap (row_wrap)
  );

  rag_addr_ctr #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .pix_en  (pix_en),
    .evt     (evt),
    .capture (capture),
    .limit   (limit),
    .addr    (disp_addr)
  );
endmodule

// File: rtl/rag_chk.sv
module rag_chk #(
  parameter int BYTES_PER_LINE = 40,
  parameter int BMP_RASTERS    = 200,
  parameter int CHR_ROWS       = 25,
  parameter int CELL_H         = 8,
  localparam int BMP_LAST = BYTES_PER_LINE * BMP_RASTERS - 1,
  localparam int CHR_LAST = BYTES_PER_LINE * CHR_ROWS - 1,
  localparam int AW = $clog2(BMP_LAST + 1),
  localparam int RW = (CELL_H > 1) ? $clog2(CELL_H) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic          hblank,
  input logic          vblank,
  input logic          char_mode,
  input logic [AW-1:0] disp_addr,
  input logic [RW-1:0] cell_row
);
  logic          ck_hb;
  logic [AW-1:0] ck_lim;

  always_ff @(posedge clk) begin
    if (rst)         ck_hb <= 1'b1;
    else if (pix_en) ck_hb <= hblank;
  end

  assign ck_lim = char_mode ? AW'(CHR_LAST) : AW'(BMP_LAST);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !hblank && !ck_hb) |=>
      (disp_addr == (($past(disp_addr) >= $past(ck_lim)) ? '0 : $past(disp_addr) + 1'b1))); // R2

  AST_HOLD_IN_HBLANK: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hblank && !vblank) |=> $stable(disp_addr)); // R3

  AST_VBLANK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (pix_en && hblank && vblank) |=> (disp_addr == '0 && cell_row == '0)); // R5

  AST_ROW_STEADY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !hblank) |=> $stable(cell_row)); // R6

  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
    disp_addr <= AW'(BMP_LAST)); // R8

  AST_BITMAP_ROW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !char_mode) |=> (cell_row == '0)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(disp_addr) && $stable(cell_row))); // R10
endmodule

bind raster_addr_gen rag_chk #(
  .BYTES_PER_LINE (BYTES_PER_LINE),
  .BMP_RASTERS    (BMP_RASTERS),
  .CHR_ROWS       (CHR_ROWS),
  .CELL_H         (CELL_H)
) i_rag_chk (.*);

// File: tb/test_raster_addr_gen.sv
module test_raster_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_en = 1'b0;
  logic        hblank = 1'b1;
  logic        vblank = 1'b0;
  logic        char_mode = 1'b0;
  logic [12:0] disp_addr;
  logic [2:0]  cell_row;

  int n_vec  = 0;
  int n_fail = 0;

  // behavioural reference state
  int    m_addr = 0, m_start = 0, m_row = 0;
  bit    m_prev = 1'b1;
  string tag = "R1";
  int    line_idx = 0;
  bit    in_frame = 1'b0;
  bit    seen_bmp_last = 1'b0, seen_chr_last = 1'b0, seen_wrap = 1'b0;
  int    last_act_addr = -1;

  always #2 clk = ~clk;

  raster_addr_gen i_raster_addr_gen (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hblank(hblank), .vblank(vblank),
    .char_mode(char_mode), .disp_addr(disp_addr), .cell_row(cell_row)
  );

  function automatic int nxt(int a, bit cm);
    int lim = cm ? 999 : 7999;
    return (a >= lim) ? 0 : a + 1;
  endfunction

  task automatic check(string t, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      m_addr = 0; m_start = 0; m_row = 0; m_prev = 1'b1; tag = "R1";
    end else if (!pix_en) begin
      tag = "R10";
    end else begin
      if (vblank && hblank) begin
        m_addr = 0; m_start = 0; m_row = 0; tag = "R5";
      end else if (hblank && !m_prev) begin
        tag = "R4";
        if (!char_mode) m_start = nxt(m_addr, 1'b0);
        else if (m_row == 7) begin m_row = 0; m_start = nxt(m_addr, 1'b1); tag = "R6"; end
        else begin m_row = m_row + 1; tag = "R6"; end
      end else if (hblank) begin
        tag = "R3";
      end else if (m_prev) begin
        m_addr = m_start; tag = "R4";
      end else begin
        m_addr = nxt(m_addr, char_mode); tag = vblank ? "R5" : "R2";
      end
      if (!char_mode) m_row = 0;
      m_prev = hblank;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, int'(disp_addr), m_addr);
    if (!char_mode) check("R9", int'(cell_row), 0);
    else check(tag, int'(cell_row), m_row);
    if (pix_en && !hblank && !vblank && in_frame) begin
      if (char_mode) check("R6", int'(cell_row), line_idx % 8);
      if (!char_mode && disp_addr == 13'd7999) seen_bmp_last = 1'b1;
      if (char_mode && disp_addr == 13'd999) seen_chr_last = 1'b1;
      if (last_act_addr >= 7999 && disp_addr == 13'd0) seen_wrap = 1'b1;
      last_act_addr = int'(disp_addr);
    end
  endtask

  task automatic one_line(bit vb, bit gap);
    for (int i = 0; i < 40; i++) begin
      pix_en = 1'b1; hblank = 1'b0; vblank = vb;
      tick();
      if (gap) begin pix_en = 1'b0; tick(); end
    end
    for (int i = 0; i < 8; i++) begin
      pix_en = 1'b1; hblank = 1'b1; vblank = vb;
      tick();
      if (gap && i == 3) begin pix_en = 1'b0; tick(); end
    end
  endtask

  task automatic frame(bit cm, int lines, bit gap);
    in_frame = 1'b0;
    one_line(1'b1, gap);
    char_mode = cm;          // mode switched only inside vertical blanking
    one_line(1'b1, gap);
    one_line(1'b1, gap);
    in_frame = 1'b1;
    last_act_addr = -1;
    for (int l = 0; l < lines; l++) begin
      line_idx = l;
      one_line(1'b0, gap);
    end
    in_frame = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    check("R1", int'(disp_addr), 0);
    check("R1", int'(cell_row), 0);
    rst = 1'b0;

    frame(1'b0, 200, 1'b0);
    check("R2", int'(seen_bmp_last), 1);

    frame(1'b1, 216, 1'b1);
    check("R7", int'(seen_chr_last), 1);

    frame(1'b0, 202, 1'b0);
    check("R8", int'(seen_wrap), 1);

    // idle cycles then a vertical-blank clear
    pix_en = 1'b0;
    repeat (5) tick();
    pix_en = 1'b1; hblank = 1'b1; vblank = 1'b1;
    tick();
    check("R5", int'(disp_addr), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule